// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Block

This block is the software-visible face of a multi-channel DMA controller. A host writes and reads 32-bit words through a simple request bus that covers a 4 KB window. The block stores five registers for each channel: source, destination, link pointer, control and configuration. It also stores a global configuration word and a sync word. All of these are driven out continuously to the transfer engine, which moves the data itself.

The engine reports progress back through one-cycle set pulses, one for terminal count and one for error, with one bit per channel. The block keeps these as sticky raw flags that software clears with write-one-to-clear words. The masks applied to the flags are not writable on their own. Each channel's mask bits are taken from two bits of that channel's configuration register. The masked flags drive three interrupt lines: error, terminal count, and their OR.

A fixed identification byte sequence sits at the top of the window. The channel count is a parameter, 8 by default or 2 for a reduced build, and the first ID byte reflects it.

Top module: `dma_regfile`

## Requirements
- R1: Channel c's registers sit at byte offset 0x100 + 32·c. Word offsets 0x0, 0x4, 0x8, 0xC and 0x10 hold source, destination, link pointer, control and configuration, all read/write. The channel index is address bits 7:5. The global configuration word is read/write at 0x030 and the sync word at 0x034. Every register is driven onto its export port from the cycle after the write.
- R2: A set pulse on `tc_set[c]` or `err_set[c]` sets raw flag c, and the flag stays set. Writing 0x008 clears each raw terminal-count flag whose data bit is 1. Writing 0x010 does the same for the raw error flags. The raw flags read back at 0x014 (terminal count) and 0x018 (error), with bit c for channel c.
- R3: Channel c's terminal-count mask is bit 15 of its configuration register, and its error mask is bit 14. Masked terminal count reads at 0x004 and masked error at 0x00C. The OR of the two reads at 0x000.
- R4: `irq_tc` is the OR of the masked terminal-count flags, and `irq_err` is the OR of the masked error flags. `irq_any` is the OR of both. All three are high in the cycle after the edge that sets a masked flag.
- R5: Offset 0x01C returns bit 0 of each channel's configuration register as bit c.
- R6: Offsets 0xFE0 to 0xFFC each return one byte, in this order: 0x80 (0x81 when the channel count is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R7: Some offsets read as zero and ignore writes. These are channel words 0x14 to 0x1C, channel indices at or above the channel count, words 0x020 to 0x02C, 0x038 to 0x0FC, and 0x200 to 0xFDC.
- R8: A read request is answered by `rd_valid` high one cycle later, with the data on `rd_data`. When `rd_valid` is low, `rd_data` is zero. Reads return the state from before any edge in the request cycle.
- R9: When a set pulse and a clear write hit the same flag bit in the same cycle, the flag ends up set.
- R10: After reset every register and flag is zero, the interrupt lines are low and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the window, word aligned |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe, one cycle after the request |
| rd_data | output | 32 | Read response data, zero when idle |
| tc_set | input | NUM_CH | Terminal-count set pulses from the engine |
| err_set | input | NUM_CH | Error set pulses from the engine |
| ch_src | output | NUM_CH*32 | Source registers, channel c at bits 32c+31:32c |
| ch_dst | output | NUM_CH*32 | Destination registers |
| ch_link | output | NUM_CH*32 | Link pointer registers |
| ch_ctrl | output | NUM_CH*32 | Control registers |
| ch_cfg | output | NUM_CH*32 | Configuration registers |
| glb_cfg | output | 32 | Global configuration word |
| glb_sync | output | 32 | Sync word |
| irq_err | output | 1 | Masked error interrupt |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_any | output | 1 | OR of both interrupts |

## Verification
The set-priority properties assume that a set pulse with its mask bit on reaches the interrupt line in the next cycle. The only exception they allow is a configuration write that changes a mask in between. The stimulus is shaped so that mask changes and pulses are easy to tell apart. It drives only word-aligned addresses and one request per cycle. It raises set pulses both on their own and together with clear writes to the same bit. The default eight-channel build has no out-of-range channel index, so the ignore rule is exercised through undefined channel words and unmapped global offsets.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int CH_IDX_W = 3;

  typedef struct packed {
    logic [DW-1:0] cfg;
    logic [DW-1:0] ctrl;
    logic [DW-1:0] link;
    logic [DW-1:0] dst;
    logic [DW-1:0] src;
  } chan_regs_t;

  typedef enum logic [2:0] {
    CW_SRC  = 3'd0,
    CW_DST  = 3'd1,
    CW_LINK = 3'd2,
    CW_CTRL = 3'd3,
    CW_CFG  = 3'd4
  } chan_word_e;

  localparam logic [3:0] GW_STAT     = 4'd0;
  localparam logic [3:0] GW_TC_STAT  = 4'd1;
  localparam logic [3:0] GW_TC_CLR   = 4'd2;
  localparam logic [3:0] GW_ERR_STAT = 4'd3;
  localparam logic [3:0] GW_ERR_CLR  = 4'd4;
  localparam logic [3:0] GW_TC_RAW   = 4'd5;
  localparam logic [3:0] GW_ERR_RAW  = 4'd6;
  localparam logic [3:0] GW_ENABLED  = 4'd7;
  localparam logic [3:0] GW_CONF     = 4'd12;
  localparam logic [3:0] GW_SYNC     = 4'd13;

  localparam int CFG_EN_BIT      = 0;
  localparam int CFG_ERRMASK_BIT = 14;
  localparam int CFG_TCMASK_BIT  = 15;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    logic [7:0] b;
    case (idx)
      3'd0:    b = (nch == 2) ? 8'h81 : 8'h80;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h0A;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [CH_IDX_W-1:0]         wr_ch,
  input  chan_word_e                  wr_word,
  input  logic [DW-1:0]               wr_data,
  output chan_regs_t [NUM_CH-1:0]     regs
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_regs_t cur_q;
    chan_regs_t cur_d;
    logic       hit;

    assign hit = wr_en && (wr_ch == CH_IDX_W'(c));

    always_comb begin
      cur_d = cur_q;
      case (wr_word)
        CW_SRC:  cur_d.src  = wr_data;
        CW_DST:  cur_d.dst  = wr_data;
        CW_LINK: cur_d.link = wr_data;
        CW_CTRL: cur_d.ctrl = wr_data;
        CW_CFG:  cur_d.cfg  = wr_data;
        default: cur_d = cur_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= '0;
      end else if (hit) begin
        cur_q <= cur_d;
      end
    end

    assign regs[c] = cur_q;
  end

endmodule

// File: rtl/dma_flag_unit.sv
module dma_flag_unit #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic [NUM_CH-1:0] tc_clr,
  input  logic [NUM_CH-1:0] err_clr,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  output logic [NUM_CH-1:0] raw_tc,
  output logic [NUM_CH-1:0] raw_err,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);

  logic [NUM_CH-1:0] tc_d, err_d;
  logic              tc_upd, err_upd;

  always_comb begin
    tc_d    = (raw_tc  & ~tc_clr)  | tc_set;
    err_d   = (raw_err & ~err_clr) | err_set;
    tc_upd  = (|tc_set)  || (|tc_clr);
    err_upd = (|err_set) || (|err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_tc <= '0;
    end else if (tc_upd) begin
      raw_tc <= tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_err <= '0;
    end else if (err_upd) begin
      raw_err <= err_d;
    end
  end

  assign irq_tc  = |(raw_tc & tc_mask);
  assign irq_err = |(raw_err & err_mask);
  assign irq_any = irq_tc | irq_err;

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [AW-1:0]           addr,
  input  chan_regs_t [NUM_CH-1:0] regs,
  input  logic [DW-1:0]           glb_cfg,
  input  logic [DW-1:0]           glb_sync,
  input  logic [NUM_CH-1:0]       raw_tc,
  input  logic [NUM_CH-1:0]       raw_err,
  input  logic [NUM_CH-1:0]       tc_mask,
  input  logic [NUM_CH-1:0]       err_mask,
  output logic [DW-1:0]           rdata
);

  localparam logic [CH_IDX_W:0] NCH_LIM = (CH_IDX_W+1)'(NUM_CH);

  logic [CH_IDX_W-1:0] ch;
  logic [2:0]          word;
  logic                ch_ok;
  chan_regs_t          sel;
  logic [NUM_CH-1:0]   enabled;

  assign ch    = addr[7:5];
  assign word  = addr[4:2];
  assign ch_ok = ({1'b0, ch} < NCH_LIM) && (word <= 3'd4);

  always_comb begin
    sel     = '0;
    enabled = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch == CH_IDX_W'(c)) sel = regs[c];
      enabled[c] = regs[c].cfg[CFG_EN_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[11:5] == 7'h7F) begin
      rdata = DW'(id_byte(addr[4:2], NUM_CH));
    end else if (addr[11:8] == 4'h1) begin
      if (ch_ok) begin
        case (chan_word_e'(word))
          CW_SRC:  rdata = sel.src;
          CW_DST:  rdata = sel.dst;
          CW_LINK: rdata = sel.link;
          CW_CTRL: rdata = sel.ctrl;
          CW_CFG:  rdata = sel.cfg;
          default: rdata = '0;
        endcase
      end
    end else if (addr[11:6] == 6'd0) begin
      case (addr[5:2])
        GW_STAT:     rdata = DW'((raw_tc & tc_mask) | (raw_err & err_mask));
        GW_TC_STAT:  rdata = DW'(raw_tc & tc_mask);
        GW_ERR_STAT: rdata = DW'(raw_err & err_mask);
        GW_TC_RAW:   rdata = DW'(raw_tc);
        GW_ERR_RAW:  rdata = DW'(raw_err);
        GW_ENABLED:  rdata = DW'(enabled);
        GW_CONF:     rdata = glb_cfg;
        GW_SYNC:     rdata = glb_sync;
        default:     rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data,
  input  logic [NUM_CH-1:0]    tc_set,
  input  logic [NUM_CH-1:0]    err_set,
  output logic [NUM_CH*DW-1:0] ch_src,
  output logic [NUM_CH*DW-1:0] ch_dst,
  output logic [NUM_CH*DW-1:0] ch_link,
  output logic [NUM_CH*DW-1:0] ch_ctrl,
  output logic [NUM_CH*DW-1:0] ch_cfg,
  output logic [DW-1:0]        glb_cfg,
  output logic [DW-1:0]        glb_sync,
  output logic                 irq_err,
  output logic                 irq_tc,
  output logic                 irq_any
);

  localparam logic [CH_IDX_W:0] NCH_LIM = (CH_IDX_W+1)'(NUM_CH);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // address decode
  logic wr, rd_fire, chan_wr, glb_hit;
  logic [3:0] gword;

  assign wr      = req_valid && req_write;
  assign rd_fire = req_valid && !req_write;
  assign chan_wr = wr && (req_addr[11:8] == 4'h1) &&
                   ({1'b0, req_addr[7:5]} < NCH_LIM) && (req_addr[4:2] <= 3'd4);
  assign glb_hit = req_addr[11:6] == 6'd0;
  assign gword   = req_addr[5:2];

  // channel register bank
  chan_regs_t [NUM_CH-1:0] regs;

  dma_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (chan_wr),
    .wr_ch   (req_addr[7:5]),
    .wr_word (chan_word_e'(req_addr[4:2])),
    .wr_data (req_wdata),
    .regs    (regs)
  );

  logic [NUM_CH-1:0] tc_mask, err_mask;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_exp
    assign ch_src [c*DW +: DW] = regs[c].src;
    assign ch_dst [c*DW +: DW] = regs[c].dst;
    assign ch_link[c*DW +: DW] = regs[c].link;
    assign ch_ctrl[c*DW +: DW] = regs[c].ctrl;
    assign ch_cfg [c*DW +: DW] = regs[c].cfg;
    assign tc_mask[c]          = regs[c].cfg[CFG_TCMASK_BIT];
    assign err_mask[c]         = regs[c].cfg[CFG_ERRMASK_BIT];
  end

  // global words
  logic          conf_we, sync_we;
  logic [DW-1:0] glb_cfg_q, glb_sync_q;

  assign conf_we = wr && glb_hit && (gword == GW_CONF);
  assign sync_we = wr && glb_hit && (gword == GW_SYNC);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      glb_cfg_q <= '0;
    end else if (conf_we) begin
      glb_cfg_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      glb_sync_q <= '0;
    end else if (sync_we) begin
      glb_sync_q <= req_wdata;
    end
  end

  assign glb_cfg  = glb_cfg_q;
  assign glb_sync = glb_sync_q;

  // status flags and interrupt lines
  logic [NUM_CH-1:0] tc_clr, err_clr, raw_tc, raw_err;

  assign tc_clr  = (wr && glb_hit && (gword == GW_TC_CLR))  ? req_wdata[NUM_CH-1:0] : '0;
  assign err_clr = (wr && glb_hit && (gword == GW_ERR_CLR)) ? req_wdata[NUM_CH-1:0] : '0;

  dma_flag_unit #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tc_set   (tc_set),
    .err_set  (err_set),
    .tc_clr   (tc_clr),
    .err_clr  (err_clr),
    .tc_mask  (tc_mask),
    .err_mask (err_mask),
    .raw_tc   (raw_tc),
    .raw_err  (raw_err),
    .irq_tc   (irq_tc),
    .irq_err  (irq_err),
    .irq_any  (irq_any)
  );

  // read path
  logic [DW-1:0] rd_mux, rd_data_d;
  logic          rd_valid_q;
  logic [DW-1:0] rd_data_q;

  dma_read_mux #(.NUM_CH(NUM_CH)) u_rmux (
    .addr     (req_addr),
    .regs     (regs),
    .glb_cfg  (glb_cfg_q),
    .glb_sync (glb_sync_q),
    .raw_tc   (raw_tc),
    .raw_err  (raw_err),
    .tc_mask  (tc_mask),
    .err_mask (err_mask),
    .rdata    (rd_mux)
  );

  assign rd_data_d = rd_fire ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_fire;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NUM_CH = 8,
  parameter int DW     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [NUM_CH-1:0]    tc_set,
  input logic [NUM_CH-1:0]    err_set,
  input logic [NUM_CH*DW-1:0] ch_cfg,
  input logic                 rd_valid,
  input logic [DW-1:0]        rd_data,
  input logic                 irq_tc,
  input logic                 irq_err
);

  logic [NUM_CH-1:0] tm, em;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_m
    assign tm[c] = ch_cfg[c*DW + 15];
    assign em[c] = ch_cfg[c*DW + 14];
  end

  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  assert_tc_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tc |-> (|tm));

  assert_err_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (|em));

  assert_tc_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tc_set & tm)) |=> (irq_tc || !$stable(ch_cfg)));

  assert_err_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_set & em)) |=> (irq_err || !$stable(ch_cfg)));

endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH), .DW(32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .tc_set    (tc_set),
  .err_set   (err_set),
  .ch_cfg    (ch_cfg),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .irq_tc    (irq_tc),
  .irq_err   (irq_err)
);

// File: tb/sim_dma_regfile.sv
module sim_dma_regfile;
  localparam int NCH = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_write;
  logic [11:0]     req_addr;
  logic [31:0]     req_wdata;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic [NCH-1:0]  tc_set, err_set;
  logic [NCH*32-1:0] ch_src, ch_dst, ch_link, ch_ctrl, ch_cfg;
  logic [31:0]     glb_cfg, glb_sync;
  logic            irq_err, irq_tc, irq_any;

  always #4 clk = ~clk;

  dma_regfile #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .tc_set(tc_set), .err_set(err_set), .ch_src(ch_src), .ch_dst(ch_dst),
    .ch_link(ch_link), .ch_ctrl(ch_ctrl), .ch_cfg(ch_cfg), .glb_cfg(glb_cfg),
    .glb_sync(glb_sync), .irq_err(irq_err), .irq_tc(irq_tc), .irq_any(irq_any)
  );

  // reference model state
  logic [31:0]    m_ch [NCH][5];
  logic [31:0]    m_glb, m_sync;
  logic [NCH-1:0] m_tc, m_err;
  logic           e_rv;
  logic [31:0]    e_rd;
  string          e_tag;
  int             n_checks = 0;
  int             n_fail   = 0;
  bit             finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NCH-1:0] tmask();
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = m_ch[c][4][15];
    return m;
  endfunction

  function automatic logic [NCH-1:0] emask();
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = m_ch[c][4][14];
    return m;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a, output string tag);
    logic [7:0] ids [8];
    int ch, wd;
    logic [31:0] v;
    ids = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (NCH == 2) ids[0] = 8'h81;
    v = 0;
    tag = "R7";
    if (a >= 12'hFE0) begin
      v = {24'b0, ids[(a - 12'hFE0) >> 2]};
      tag = "R6";
    end else if (a >= 12'h100 && a < 12'h200) begin
      ch = (a >> 5) & 7;
      wd = (a >> 2) & 7;
      if (ch < NCH && wd < 5) begin
        v = m_ch[ch][wd];
        tag = "R1";
      end
    end else if (a < 12'h040) begin
      case (a >> 2)
        0:  begin v = 32'((m_tc & tmask()) | (m_err & emask())); tag = "R3"; end
        1:  begin v = 32'(m_tc & tmask());  tag = "R3"; end
        3:  begin v = 32'(m_err & emask()); tag = "R3"; end
        5:  begin v = 32'(m_tc);  tag = "R2"; end
        6:  begin v = 32'(m_err); tag = "R2"; end
        7:  begin
              for (int c = 0; c < NCH; c++) v[c] = m_ch[c][4][0];
              tag = "R5";
            end
        12: begin v = m_glb;  tag = "R1"; end
        13: begin v = m_sync; tag = "R1"; end
        default: begin v = 0; tag = "R7"; end
      endcase
    end
    return v;
  endfunction

  task automatic model_step(input logic v, input logic w, input logic [11:0] a,
                            input logic [31:0] d, input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
    logic [NCH-1:0] tcc, erc;
    string t;
    int ch, wd;
    tcc = '0;
    erc = '0;
    if (v && !w) begin
      e_rv = 1'b1;
      e_rd = model_read(a, t);
      e_tag = t;
    end else begin
      e_rv = 1'b0;
      e_rd = '0;
      e_tag = "R8";
    end
    if (v && w) begin
      if (a >= 12'h100 && a < 12'h200) begin
        ch = (a >> 5) & 7;
        wd = (a >> 2) & 7;
        if (ch < NCH && wd < 5) m_ch[ch][wd] = d;
      end else if (a < 12'h040) begin
        case (a >> 2)
          2:  tcc = d[NCH-1:0];
          4:  erc = d[NCH-1:0];
          12: m_glb = d;
          13: m_sync = d;
          default: ;
        endcase
      end
    end
    m_tc  = (m_tc  & ~tcc) | ts;   // R9: set wins
    m_err = (m_err & ~erc) | es;
  endtask

  task automatic compare_all();
    logic itc, ier;
    itc = |(m_tc & tmask());
    ier = |(m_err & emask());
    chk(rd_valid == e_rv, "R8", 32'(rd_valid), 32'(e_rv));
    chk(rd_data == e_rd, e_tag, rd_data, e_rd);
    chk(irq_tc == itc, "R4", 32'(irq_tc), 32'(itc));
    chk(irq_err == ier, "R4", 32'(irq_err), 32'(ier));
    chk(irq_any == (itc | ier), "R4", 32'(irq_any), 32'(itc | ier));
    chk(glb_cfg == m_glb, "R1", glb_cfg, m_glb);
    chk(glb_sync == m_sync, "R1", glb_sync, m_sync);
    for (int c = 0; c < NCH; c++) begin
      chk(ch_src [c*32 +: 32] == m_ch[c][0], "R1", ch_src [c*32 +: 32], m_ch[c][0]);
      chk(ch_dst [c*32 +: 32] == m_ch[c][1], "R1", ch_dst [c*32 +: 32], m_ch[c][1]);
      chk(ch_link[c*32 +: 32] == m_ch[c][2], "R1", ch_link[c*32 +: 32], m_ch[c][2]);
      chk(ch_ctrl[c*32 +: 32] == m_ch[c][3], "R1", ch_ctrl[c*32 +: 32], m_ch[c][3]);
      chk(ch_cfg [c*32 +: 32] == m_ch[c][4], "R1", ch_cfg [c*32 +: 32], m_ch[c][4]);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
    @(negedge clk);
    compare_all();
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    tc_set = ts; err_set = es;
    model_step(v, w, a, d, ts, es);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, '0, '0);
  endtask

  task automatic rd(input logic [11:0] a);
    step(1'b1, 1'b0, a, 32'h0, '0, '0);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 12'h0, 32'h0, '0, '0);
  endtask

  task automatic pulse(input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
    step(1'b0, 1'b0, 12'h0, 32'h0, ts, es);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    tc_set = 0; err_set = 0;
    for (int c = 0; c < NCH; c++) for (int w = 0; w < 5; w++) m_ch[c][w] = 0;
    m_glb = 0; m_sync = 0; m_tc = 0; m_err = 0;
    e_rv = 0; e_rd = 0; e_tag = "R10";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state at the ports
    chk(rd_valid == 1'b0, "R10", 32'(rd_valid), 32'h0);
    chk(irq_any == 1'b0, "R10", 32'(irq_any), 32'h0);
    chk(ch_cfg == '0, "R10", ch_cfg[31:0], 32'h0);
    rst_n = 1'b1;
    repeat (3) idle();
    rd(12'h01C); rd(12'h014); rd(12'h150);

    // R1: channel registers and global words
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 5; w++)
        wr(12'h100 + 12'(c*32 + w*4),
           (w == 4) ? {16'hC0DE, 16'(c*16 + (c % 2))} : 32'(32'h1000_0000 * (w+1) + c*32'h0101));
    wr(12'h030, 32'hA5A5_0003);
    wr(12'h034, 32'h0000_BEEF);
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 5; w++) rd(12'h100 + 12'(c*32 + w*4));
    rd(12'h030); rd(12'h034);

    // R7: undefined words ignored and read zero
    wr(12'h154, 32'hFFFF_FFFF); wr(12'h158, 32'hFFFF_FFFF); wr(12'h15C, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF); wr(12'h03C, 32'hFFFF_FFFF); wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h154); rd(12'h15C); rd(12'h020); rd(12'h02C); rd(12'h03C); rd(12'h800);
    rd(12'h140); rd(12'h150); rd(12'h030);

    // R6: ID bytes
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(i*4));

    // R5: enabled bitmap
    rd(12'h01C);

    // R2/R3/R4: flags, masks, interrupts
    wr(12'h130, 32'h0000_8001);  // ch1 tc mask, enable
    wr(12'h170, 32'h0000_4000);  // ch3 error mask
    pulse(8'b0000_0100, 8'b0010_0000);  // unmasked: no irq
    idle();
    rd(12'h014); rd(12'h018); rd(12'h000);
    pulse(8'b0000_0010, 8'b0000_0000);
    idle();
    rd(12'h004); rd(12'h000);
    pulse(8'b0000_0000, 8'b0000_1000);
    idle();
    rd(12'h00C); rd(12'h000); rd(12'h01C);
    wr(12'h008, 32'h0000_0002);  // clear ch1 tc
    rd(12'h014); rd(12'h004);
    wr(12'h010, 32'h0000_0020);  // clear unmasked ch5 err only
    rd(12'h018);
    wr(12'h170, 32'h0000_0000);  // R3: drop ch3 error mask
    rd(12'h00C); rd(12'h018);
    wr(12'h170, 32'h0000_4000);
    idle();

    // R9: set and clear on the same bit, same cycle
    step(1'b1, 1'b1, 12'h008, 32'h0000_0006, 8'b0000_0010, 8'b0000_0000);
    rd(12'h014);
    step(1'b1, 1'b1, 12'h010, 32'h0000_00FF, 8'b0000_0000, 8'b0000_1000);
    rd(12'h018);
    wr(12'h008, 32'h0000_00FF);
    wr(12'h010, 32'h0000_00FF);
    rd(12'h014); rd(12'h018); rd(12'h000);
    repeat (2) idle();

    @(negedge clk);
    compare_all();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule